// File: doc/BRIEF.md
# Queued Interrupt Vector Reporter

This block holds the interrupt causes of a two-channel serial controller in arrival order and presents them to a processor one at a time. Each cause is a 3-bit code pushed by the receive or transmit logic. While at least one cause is waiting, the block holds its interrupt request high.

The processor finds out why it was interrupted by a vector read through the channel B control port. Channel B uses a pointer protocol. A write while the pointer is 0 loads the pointer. The next access then reaches the register the pointer names, and that access returns the pointer to 0. When the pointer names register 2, a read returns the oldest cause code merged with a vector base, and that base is programmed by a write to register 2. The read leaves the queue unchanged. The processor retires the cause it has serviced with an end-of-interrupt strobe. An interrupt-pending status bit records that the processor has taken a vector and has not yet retired the last cause.

Top module: `irqq_reporter`

## Requirements
- R1: After a synchronous reset the block is in this state: `irq` low, `int_pending` low, `b_rdata` zero, the channel B pointer 0, the vector base 0 and the queue empty.
- R2: A push into a queue that is not full makes `irq` high on the next cycle. `irq` stays high for as long as the queue holds at least one cause.
- R3: A read with the pointer at 2 and a non-empty queue returns, on the next cycle, the vector base in bits [7:3] and the oldest cause code in bits [2:0]. The read does not remove the entry.
- R4: A read with the pointer at 2 and an empty queue returns the vector base in bits [7:3] and the no-interrupt code 3'b110 in bits [2:0].
- R5: A read with the pointer at any value other than 2 returns zero. Every read, and every write made while the pointer is not 0, sets the pointer back to 0. A write while the pointer is 0 loads the pointer from `b_wdata[2:0]`. A write while the pointer is 2 loads the vector base from `b_wdata[7:3]`.
- R6: A read with the pointer at 2 that finds the queue non-empty sets `int_pending`.
- R7: An end-of-interrupt strobe removes the oldest entry. Causes are therefore reported in the order they were pushed. A strobe on an empty queue has no effect.
- R8: An end-of-interrupt that removes the last entry clears `int_pending` and drops `irq` on the next cycle. If entries remain, both signals keep their values.
- R9: A push into a full queue (DEPTH entries, 4 by default) is dropped. The entries already queued are kept unchanged.
- R10: The queue wraps around its storage. Arrival order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cause_push | input | 1 | Strobe that appends `cause_code` to the queue |
| cause_code | input | 3 | Cause code to append (receive 3'b010, transmit 3'b001) |
| b_wr | input | 1 | Channel B control write strobe |
| b_wdata | input | 8 | Channel B control write data |
| b_rd | input | 1 | Channel B control read strobe; takes priority over `b_wr` |
| eoi | input | 1 | End-of-interrupt strobe |
| b_rdata | output | 8 | Registered data of the most recent channel B read |
| irq | output | 1 | Level interrupt request, high while causes are queued |
| int_pending | output | 1 | Interrupt-pending status bit |

## Verification
On every cycle the assertions check four things. The occupancy count never goes above DEPTH. An accepted push always leaves the queue non-empty. A retire reduces the occupancy by exactly one. Each read returns the pointer to 0, and a read at any pointer other than 2 returns zero. They also check that retiring the last entry clears the pending bit. The values of the reported vectors cannot be covered by these cycle checks: their order, the no-interrupt code, the order kept after an overflow and across a wrap, and the effect of a mid-run reset. The bench scenarios show those by comparing every vector read with the cause sequence it pushed.

// File: rtl/irqq_pkg.sv
// Package: shared cause-code encodings and widths for the interrupt reporter.
// Assumes an 8-bit control data path with the cause code in the low bits.
package irqq_pkg;
    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] cause_t;
    localparam cause_t CAUSE_TX   = 3'b001;
    localparam cause_t CAUSE_RX   = 3'b010;
    localparam cause_t CAUSE_NONE = 3'b110;
    localparam logic [2:0] VEC_REG_IDX = 3'd2;
endpackage

// File: rtl/irqq_fifo.sv
// Circular queue of cause codes.
// What it does: appends on push, removes the head on pop, and exposes the head and the occupancy.
// Assumes: a push into a full queue is dropped, even when a pop happens in the same cycle,
// and a pop on an empty queue does nothing. DEPTH need not be a power of two.
module irqq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH-1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_idx];

    // Write the accepted cause into the tail slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= push_data;
    end

    // Advance the indices with wrap and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            if (do_pop)  rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    assert_push_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> !empty);
    assert_pop_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/irqq_chb.sv
// Channel B pointer port and vector base register.
// What it does: decodes pointer-based writes and reads, holds the vector base,
// and registers the read data.
// Assumes: a read takes priority over a write in the same cycle, and only register 2 is stored here.
module irqq_chb #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic [CODE_W-1:0] head,
    input  logic              empty,
    output logic [DATA_W-1:0] rdata,
    output logic              vec_read
);
    import irqq_pkg::*;
    localparam int BASE_W = DATA_W - CODE_W;

    logic [2:0]        ptr;
    logic [BASE_W-1:0] vec_base;
    logic [CODE_W-1:0] code_sel;

    assign vec_read = rd && (ptr == VEC_REG_IDX);
    assign code_sel = empty ? CAUSE_NONE : head;

    // Pointer sequencing and vector base loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            vec_base <= '0;
        end else if (rd) begin
            ptr <= '0;
        end else if (wr) begin
            if (ptr == 3'd0) begin
                ptr <= wdata[2:0];
            end else begin
                if (ptr == VEC_REG_IDX) vec_base <= wdata[DATA_W-1:CODE_W];
                ptr <= '0;
            end
        end
    end

    // Register the read data: the merged vector or zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata <= '0;
        else if (vec_read) rdata <= {vec_base, code_sel};
        else if (rd)       rdata <= '0;
    end

    assert_ptr_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (ptr == 3'd0));
    assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ptr != VEC_REG_IDX) |=> (rdata == '0));
endmodule

// File: rtl/irqq_reporter.sv
// Queued interrupt vector reporter (top).
// What it does: queues cause codes, raises a level interrupt while any are queued,
// answers vector reads through channel B, and retires the head on end-of-interrupt.
// Assumes: a vector read and a retire of the last entry in the same cycle leave pending clear.
module irqq_reporter #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_push,
    input  logic [2:0]        cause_code,
    input  logic              b_wr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_rd,
    input  logic              eoi,
    output logic [DATA_W-1:0] b_rdata,
    output logic              irq,
    output logic              int_pending
);
    import irqq_pkg::*;
    localparam int CNT_W = $clog2(DEPTH+1);

    cause_t           head;
    logic             empty, full, vec_read;
    logic [CNT_W-1:0] count;

    irqq_fifo #(.DEPTH(DEPTH), .W(CODE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(cause_push), .push_data(cause_code),
        .pop(eoi), .head(head), .empty(empty), .full(full), .count(count)
    );

    irqq_chb #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chb (
        .clk(clk), .rst_n(rst_n), .wr(b_wr), .wdata(b_wdata), .rd(b_rd),
        .head(head), .empty(empty), .rdata(b_rdata), .vec_read(vec_read)
    );

    assign irq = !empty;

    // Pending bit: set by a vector read of a waiting cause, cleared when the last cause retires.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   int_pending <= 1'b0;
        else if (eoi && count == CNT_W'(1) && !cause_push) int_pending <= 1'b0;
        else if (vec_read && !empty)                  int_pending <= 1'b1;
    end

    assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && count == CNT_W'(1) && !cause_push) |=> (!int_pending && !irq));
    assert_pending_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_read && !empty && !eoi) |=> int_pending);
endmodule

// File: tb/irqq_reporter_bench.sv
module irqq_reporter_bench;
    localparam logic [1:0] OP_PUSH = 2'd0, OP_EOI = 2'd1, OP_BWR = 2'd2, OP_BRD = 2'd3;
    // entry: op[20:19], data[18:11], check_rd[10], rd[9:2], irq[1], pend[0]
    localparam int N = 18;
    localparam logic [20:0] TBL [N] = '{
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b0, 1'b0},
        {OP_BWR,  8'hA8, 1'b0, 8'h00, 1'b0, 1'b0},
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b0, 1'b0},
        {OP_BRD,  8'h00, 1'b1, 8'hAE, 1'b0, 1'b0},  // R4 empty read
        {OP_PUSH, 8'h02, 1'b0, 8'h00, 1'b1, 1'b0},  // R2
        {OP_PUSH, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b1, 1'b0},
        {OP_BRD,  8'h00, 1'b1, 8'hAA, 1'b1, 1'b1},  // R3 R6
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b1, 1'b1},
        {OP_BRD,  8'h00, 1'b1, 8'hAA, 1'b1, 1'b1},  // R3 no pop
        {OP_BRD,  8'h00, 1'b1, 8'h00, 1'b1, 1'b1},  // R5 pointer back at 0
        {OP_EOI,  8'h00, 1'b0, 8'h00, 1'b1, 1'b1},  // R7
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b1, 1'b1},
        {OP_BRD,  8'h00, 1'b1, 8'hA9, 1'b1, 1'b1},  // R7 order
        {OP_EOI,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0},  // R8
        {OP_EOI,  8'h00, 1'b0, 8'h00, 1'b0, 1'b0},  // R7 empty eoi
        {OP_BWR,  8'h02, 1'b0, 8'h00, 1'b0, 1'b0},
        {OP_BRD,  8'h00, 1'b1, 8'hAE, 1'b0, 1'b0}   // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cause_push = 1'b0, b_wr = 1'b0, b_rd = 1'b0, eoi = 1'b0;
    logic [2:0] cause_code = '0;
    logic [7:0] b_wdata = '0;
    logic [7:0] b_rdata;
    logic       irq, int_pending;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irqq_reporter u_irqq_reporter (
        .clk(clk), .rst_n(rst_n), .cause_push(cause_push), .cause_code(cause_code),
        .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd), .eoi(eoi),
        .b_rdata(b_rdata), .irq(irq), .int_pending(int_pending)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        cause_push = (op == OP_PUSH); cause_code = d[2:0];
        eoi = (op == OP_EOI);
        b_wr = (op == OP_BWR); b_rd = (op == OP_BRD); b_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cause_push = 1'b0; eoi = 1'b0; b_wr = 1'b0; b_rd = 1'b0;
    endtask

    task automatic vread(input string req, input logic [7:0] exp);
        step(OP_BWR, 8'h02);
        step(OP_BRD, 8'h00);
        check(req, b_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pending", {7'd0, int_pending}, 8'h00);
        check("R1 rdata", b_rdata, 8'h00);

        for (int i = 0; i < N; i++) begin
            step(TBL[i][20:19], TBL[i][18:11]);
            if (TBL[i][10]) check("R3/R4/R5 vector", b_rdata, TBL[i][9:2]);
            check("R2/R8 irq", {7'd0, irq}, {7'd0, TBL[i][1]});
            check("R6/R8 pending", {7'd0, int_pending}, {7'd0, TBL[i][0]});
        end

        // R9: overflow drops the fifth push
        for (int k = 1; k <= 5; k++) step(OP_PUSH, 8'(k));
        for (int k = 1; k <= 4; k++) begin
            vread("R9 order", 8'hA8 | 8'(k));
            step(OP_EOI, 8'h00);
        end
        check("R9 drained irq", {7'd0, irq}, 8'h00);
        vread("R9 dropped entry absent", 8'hAE);

        // R10: wrap keeps order
        step(OP_PUSH, 8'h06); step(OP_PUSH, 8'h07);
        step(OP_EOI, 8'h00);
        step(OP_PUSH, 8'h01); step(OP_PUSH, 8'h02); step(OP_PUSH, 8'h03);
        vread("R10 wrap head", 8'hAF);
        for (int k = 1; k <= 3; k++) begin
            step(OP_EOI, 8'h00);
            vread("R10 wrap order", 8'hA8 | 8'(k));
        end
        check("R10 pending", {7'd0, int_pending}, 8'h01);
        step(OP_EOI, 8'h00);
        check("R8 last retire pending", {7'd0, int_pending}, 8'h00);

        // R5: write with nonzero pointer other than 2 leaves base and resets pointer
        step(OP_BWR, 8'h03); step(OP_BWR, 8'hF0);
        step(OP_BRD, 8'h00);
        check("R5 ptr reset after write", b_rdata, 8'h00);
        vread("R5 base unchanged", 8'hAE);

        // R1: mid-run reset clears queue, base and pending
        step(OP_PUSH, 8'h02);
        vread("R6 pending before reset", 8'hAA);
        do_reset();
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        check("R1 pending after reset", {7'd0, int_pending}, 8'h00);
        vread("R1 base cleared", 8'h06);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule